// File: doc/BRIEF.md
# Exception-Return Status Shift Unit

This block computes the machine state that results from a return from an exception or from a non-maskable interrupt. The status word keeps a small stack of saved mode bits. A return pops that stack by moving the low field of the status word down by a fixed distance, while the two top bits stay in place. When the popped state selects user mode, the kernel stack pointer is put aside and the user stack pointer becomes the active one.

Two flags are then adjusted. The pending flag is set only if the status word from before the pop had its return-lock flag clear. A return from a non-maskable interrupt also sets the top mode flag. Instruction decode sits outside the block: a single strobe and a kind bit select the operation.

All results are registered. The outputs change on the clock edge where the strobe is sampled high and hold their values in every other cycle. The reset input is asynchronous and active low. It is released through a two-stage synchronizer.

Top module: `esr_return_unit`

## Requirements
- R1: While reset is active, and after it is released until the first strobe, `stat_out`, `sp_out` and `ksp_out` are all zero.
- R2: In a cycle where `ret_en` is low, `stat_out`, `sp_out` and `ksp_out` keep their values, whatever the other inputs do.
- R3: On a strobe, bits 31 and 30 of the new status equal the same bits of `stat_in`. Bits 17..0 take old bits 27..10. Bits 29..18 are zero. Flag forcing in R4 and R6 is ORed on top of this.
- R4: On a strobe, status bit 7 (pending) is forced to 1 when old bit 8 (return lock) is 0. When old bit 8 is 1, bit 7 is simply old bit 17.
- R5: A strobe with `ret_nmi` = 0 (exception return) does not force bit 30. Bit 30 keeps its old value.
- R6: A strobe with `ret_nmi` = 1 (NMI return) always sets status bit 30.
- R7: On a strobe where the popped bit 6 (user mode, that is old bit 16) is 1, `ksp_out` takes `sp_in` and `sp_out` takes `usp_in`.
- R8: On a strobe where the popped bit 6 is 0, `sp_out` takes `sp_in` and `ksp_out` keeps its value.
- R9: Each return completes in one clock. Outputs reflect a strobe on the edge where it is sampled, and strobes in consecutive cycles each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_en | input | 1 | Return strobe, one cycle per return |
| ret_nmi | input | 1 | 1 = NMI return, 0 = exception return |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | User stack pointer |
| stat_out | output | 32 | Registered new status word |
| sp_out | output | 32 | Registered new stack pointer |
| ksp_out | output | 32 | Registered saved kernel stack pointer |

## Verification
The embedded properties check the following on every cycle:
- holding when no strobe is present;
- the top status bit passing through the pop;
- the pending flag being set when the old lock flag is clear;
- the mode flag on NMI returns;
- both directions of the stack-pointer choice.

Only the bench scenarios show the full shifted field, including the dropped bits 29..28, and the case where the lock flag is set so that the pending bit comes from the stack. They also cover a kernel pointer that persists across several later non-user returns, and back-to-back strobes. A behavioural model compares all three outputs every clock.

// File: rtl/esr_pkg.sv
package esr_pkg;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;

  typedef struct packed {
    logic load_stat;
    logic load_sp;
    logic load_ksp;
  } esr_load_t;

endpackage

// File: rtl/esr_rst_sync.sv
module esr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/esr_stack_pop.sv
module esr_stack_pop #(
  parameter int W         = 32,
  parameter int FIELD_MSB = 27,
  parameter int KEEP_LSB  = 30,
  parameter int SHIFT     = 10
) (
  input  logic [W-1:0] old_stat,
  output logic [W-1:0] popped
);

  localparam logic [W-1:0] KEEP_MASK  = {W{1'b1}} << KEEP_LSB;
  localparam logic [W-1:0] FIELD_MASK = {W{1'b1}} >> (W - 1 - FIELD_MSB);

  logic [W-1:0] kept;
  logic [W-1:0] field;

  always_comb begin
    kept   = old_stat & KEEP_MASK;
    field  = (old_stat & FIELD_MASK) >> SHIFT;
    popped = kept | field;
  end

endmodule

// File: rtl/esr_flag_fix.sv
module esr_flag_fix
  import esr_pkg::*;
#(
  parameter int W     = 32,
  parameter int P_BIT = 7,
  parameter int M_BIT = 30
) (
  input  logic      [W-1:0] popped,
  input  logic              old_lock,
  input  ret_kind_e         kind,
  output logic      [W-1:0] fixed
);

  logic [W-1:0] force_mask;

  always_comb begin
    force_mask = '0;
    if (!old_lock) begin
      force_mask[P_BIT] = 1'b1;
    end
    if (kind == RET_NMI) begin
      force_mask[M_BIT] = 1'b1;
    end
    fixed = popped | force_mask;
  end

endmodule

// File: rtl/esr_sp_swap.sv
module esr_sp_swap #(
  parameter int W = 32
) (
  input  logic         user_mode,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  output logic [W-1:0] sp_next,
  output logic         ksp_save,
  output logic [W-1:0] ksp_next
);

  always_comb begin
    ksp_save = user_mode;
    ksp_next = sp_in;
    if (user_mode) begin
      sp_next = usp_in;
    end else begin
      sp_next = sp_in;
    end
  end

endmodule

// File: rtl/esr_return_unit.sv
module esr_return_unit
  import esr_pkg::*;
#(
  parameter int W         = 32,
  parameter int SHIFT     = 10,
  parameter int FIELD_MSB = 27,
  parameter int KEEP_LSB  = 30,
  parameter int U_BIT     = 6,
  parameter int P_BIT     = 7,
  parameter int R_BIT     = 8,
  parameter int M_BIT     = 30,
  parameter int SYNC_STG  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ret_en,
  input  logic         ret_nmi,
  input  logic [W-1:0] stat_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  output logic [W-1:0] stat_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] ksp_out
);

  localparam int OLD_U_BIT = U_BIT + SHIFT;

  logic         rst_sync_n;
  logic [W-1:0] popped;
  logic [W-1:0] stat_d;
  logic [W-1:0] sp_d;
  logic [W-1:0] ksp_d;
  logic         ksp_save;
  ret_kind_e    kind;
  esr_load_t    load;

  logic [W-1:0] stat_q;
  logic [W-1:0] sp_q;
  logic [W-1:0] ksp_q;

  esr_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  esr_stack_pop #(
    .W(W), .FIELD_MSB(FIELD_MSB), .KEEP_LSB(KEEP_LSB), .SHIFT(SHIFT)
  ) u_pop (
    .old_stat (stat_in),
    .popped   (popped)
  );

  assign kind = ret_nmi ? RET_NMI : RET_EXC;

  esr_flag_fix #(.W(W), .P_BIT(P_BIT), .M_BIT(M_BIT)) u_fix (
    .popped   (popped),
    .old_lock (stat_in[R_BIT]),
    .kind     (kind),
    .fixed    (stat_d)
  );

  esr_sp_swap #(.W(W)) u_swap (
    .user_mode (popped[U_BIT]),
    .sp_in     (sp_in),
    .usp_in    (usp_in),
    .sp_next   (sp_d),
    .ksp_save  (ksp_save),
    .ksp_next  (ksp_d)
  );

  // Clock enables for each register
  always_comb begin
    load.load_stat = ret_en;
    load.load_sp   = ret_en;
    load.load_ksp  = ret_en & ksp_save;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= '0;
      sp_q   <= '0;
      ksp_q  <= '0;
    end else begin
      if (load.load_stat) stat_q <= stat_d;
      if (load.load_sp)   sp_q   <= sp_d;
      if (load.load_ksp)  ksp_q  <= ksp_d;
    end
  end

  assign stat_out = stat_q;
  assign sp_out   = sp_q;
  assign ksp_out  = ksp_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ret_en |=> ($stable(stat_out) && $stable(sp_out) && $stable(ksp_out)));

  assert_top_keep_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ret_en |=> (stat_out[W-1] == $past(stat_in[W-1])));

  assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_en && !stat_in[R_BIT]) |=> stat_out[P_BIT]);

  assert_nmi_mode_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_en && ret_nmi) |=> stat_out[M_BIT]);

  assert_exc_mode_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_en && !ret_nmi) |=> (stat_out[M_BIT] == $past(stat_in[M_BIT])));

  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_en && stat_in[OLD_U_BIT]) |=>
      (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

  assert_noswap_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_en && !stat_in[OLD_U_BIT]) |=>
      (sp_out == $past(sp_in) && $stable(ksp_out)));

endmodule

// File: tb/tb_esr_return_unit.sv
`timescale 1ns/1ps
module tb_esr_return_unit;

  logic        clk;
  logic        rst_n;
  logic        ret_en;
  logic        ret_nmi;
  logic [31:0] stat_in;
  logic [31:0] sp_in;
  logic [31:0] usp_in;
  logic [31:0] stat_out;
  logic [31:0] sp_out;
  logic [31:0] ksp_out;

  logic [31:0] m_stat, m_sp, m_ksp;
  int          total;
  int          bad;
  bit          done;
  string       phase;

  esr_return_unit dut (
    .clk(clk), .rst_n(rst_n), .ret_en(ret_en), .ret_nmi(ret_nmi),
    .stat_in(stat_in), .sp_in(sp_in), .usp_in(usp_in),
    .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_stat(logic [31:0] s, bit nmi);
    logic [31:0] r;
    r = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    if (s[8] == 1'b0) r = r | 32'h0000_0080;
    if (nmi) r = r | 32'h4000_0000;
    return r;
  endfunction

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_sp = 0; m_ksp = 0;
    end else if (ret_en) begin
      m_stat = ref_stat(stat_in, ret_nmi);
      if (((stat_in >> 16) & 1) == 1) begin
        m_ksp = sp_in;
        m_sp  = usp_in;
      end else begin
        m_sp = sp_in;
      end
    end
  end

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check32(phase, "model stat", stat_out, m_stat);
      check32(phase, "model sp",   sp_out,   m_sp);
      check32(phase, "model ksp",  ksp_out,  m_ksp);
    end
  end

  task automatic do_ret(logic [31:0] s, logic [31:0] sp, logic [31:0] usp, bit nmi);
    @(negedge clk);
    stat_in = s; sp_in = sp; usp_in = usp; ret_nmi = nmi; ret_en = 1'b1;
    @(negedge clk);
    ret_en = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0; phase = "R1";
    rst_n = 1'b0; ret_en = 1'b0; ret_nmi = 1'b0;
    stat_in = 32'hFFFF_FFFF; sp_in = 32'h1111_1111; usp_in = 32'h2222_2222;
    repeat (4) @(negedge clk);
    check32("R1", "reset stat", stat_out, 32'h0);
    check32("R1", "reset sp", sp_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check32("R1", "post-reset ksp", ksp_out, 32'h0);

    phase = "R4";
    do_ret(32'h0000_0000, 32'h0000_1000, 32'h0000_2000, 1'b0);
    check32("R4", "pending forced", stat_out, 32'h0000_0080);
    check32("R8", "sp kept", sp_out, 32'h0000_1000);
    check32("R8", "ksp held", ksp_out, 32'h0);

    phase = "R7";
    do_ret(32'hFFFF_FFFF, 32'hAAAA_0000, 32'h5555_0000, 1'b0);
    check32("R3", "full pop", stat_out, 32'hC003_FFFF);
    check32("R7", "sp from usp", sp_out, 32'h5555_0000);
    check32("R7", "ksp saved", ksp_out, 32'hAAAA_0000);

    phase = "R6";
    do_ret(32'h0000_0100, 32'h0000_3000, 32'h0000_4000, 1'b1);
    check32("R6", "nmi mode set, lock blocks pending", stat_out, 32'h4000_0000);
    check32("R8", "ksp persists", ksp_out, 32'hAAAA_0000);

    phase = "R5";
    do_ret(32'h0002_0100, 32'h0, 32'h0, 1'b0);
    check32("R5", "no mode force", stat_out, 32'h0000_0080);

    phase = "R3";
    do_ret(32'h3000_0000, 32'h7, 32'h8, 1'b0);
    check32("R3", "bits 29..28 dropped", stat_out, 32'h0000_0080);

    phase = "R2";
    stat_in = 32'h1234_5678; sp_in = 32'hDEAD_BEEF; usp_in = 32'hCAFE_F00D; ret_nmi = 1;
    repeat (5) @(negedge clk);
    #1;
    check32("R2", "hold stat", stat_out, 32'h0000_0080);
    check32("R2", "hold sp", sp_out, 32'h7);
    check32("R2", "hold ksp", ksp_out, 32'hAAAA_0000);

    phase = "R9";
    @(negedge clk);
    stat_in = 32'h0001_0000; sp_in = 32'h10; usp_in = 32'h20; ret_nmi = 0; ret_en = 1;
    @(negedge clk);
    #1;
    check32("R9", "first strobe sp", sp_out, 32'h20);
    stat_in = 32'h8000_0100; sp_in = 32'h30; usp_in = 32'h40; ret_nmi = 1;
    @(negedge clk);
    ret_en = 0;
    #1;
    check32("R9", "second strobe stat", stat_out, 32'hC000_0000);
    check32("R9", "second strobe ksp", ksp_out, 32'h10);

    phase = "R3";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      stat_in = $urandom; sp_in = $urandom; usp_in = $urandom;
      ret_nmi = $urandom_range(0, 1);
      ret_en  = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    ret_en = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule